// File: doc/BRIEF.md
# E1 Framer Interrupt Aggregator

This block gathers the event sources of an E1 framer into one active-high, level interrupt request. There are eight sources: three packet-controller event lines, a proximity check on the jitter buffer fill level, one-second and five-second timer status bits, a combined far-end alarm / CRC error status bit, and a change watch over the four-bit receive signaling code of every channel. Each source sets a sticky flag. The interrupt is raised while any flag is set whose mask bit is 1.

Software writes the 8-bit mask through a single-cycle write strobe and reads it back on a dedicated output. It reads the flags on their own output and clears them with a strobe that carries a per-source bit vector. The block keeps its own copy of the last signaling code of each channel, so the framer only has to present each new code with a valid strobe.

Top module: `frm_irq_agg`

## Requirements
- R1: The mask register is 0x00 after reset. When `mask_wr` is high at a clock edge, `mask_wdata` is loaded, and `mask_rdata` shows it from that edge on. The mask and flag bit positions are: 7 = packet controller 0, 6 = packet controller 1, 5 = packet controller 2, 4 = jitter buffer, 3 = one-second, 2 = five-second, 1 = alarm/CRC, 0 = signaling.
- R2: `irq` is high exactly when `flags & mask_rdata` is non-zero. Mask bit 1 enables its source and 0 blocks it. A source whose mask bit is 0 still sets its flag.
- R3: The one-second, five-second and alarm/CRC flags are set only by a 0-to-1 transition of their status input. A status held high does not set its flag again after it has been cleared.
- R4: The jitter flag is set when the fill level enters the near-underflow zone (level ≤ 4) or the near-overflow zone (level ≥ DEPTH − 4, DEPTH = 32 by default). A level that stays in a zone, or that is strictly between the zones, does not set the flag.
- R5: A set flag stays set until a clear strobe selects it.
- R6: With `flag_clr` high at a clock edge, each flag whose bit in `flag_clr_bits` is 1 is cleared, and the other flags are left as they are. If a flag's trigger is present in the same cycle as its clear, the flag stays set.
- R7: When `sig_valid` is high, the code `sig_abcd` for channel `sig_chan` is compared with that channel's stored copy. The signaling flag is set if any of the four bits differs, and the stored copy is updated to the new code. Channels are numbered 0 to NUM_CH − 1 (30 by default).
- R8: A strobe with `sig_chan` ≥ NUM_CH sets no flag and changes no stored copy.
- R9: A packet controller event line that is high at a clock edge sets its flag at that edge. This holds on every cycle the line is high, including the cycle of a clear.
- R10: Reset clears all flags, the mask and every channel's stored signaling copy (to 0000). `irq` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdlc_evt | input | 3 | Event lines of packet controllers 0..2 (bit i = controller i) |
| jit_level | input | 6 | Jitter buffer fill level in bytes |
| sec1_stat | input | 1 | One-second timer status |
| sec5_stat | input | 1 | Five-second timer status |
| alarm_stat | input | 1 | Combined far-end alarm / CRC error status |
| sig_valid | input | 1 | A signaling code is presented this cycle |
| sig_chan | input | 5 | Channel number of the presented code |
| sig_abcd | input | 4 | Presented four-bit signaling code |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| mask_rdata | output | 8 | Current mask value |
| flag_clr | input | 1 | Flag clear strobe |
| flag_clr_bits | input | 8 | Flags to clear, same bit positions as the mask |
| flags | output | 8 | Sticky source flags |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is driven to a known value throughout, including the reset cycles. The rise-detection properties also depend on the first cycle after reset comparing against the reset copy, not against the last value before reset. The bench meets this by driving every input from a known idle state at time zero: the status lines low, the fill level at mid-range and no strobes. It changes inputs only just after the falling edge, and it keeps the fill level and the channel numbers within their declared widths while deliberately including the two unused channel codes above NUM_CH − 1.

// File: rtl/fint_pkg.sv
package fint_pkg;

    localparam int SRC_N = 8;

    // flag / mask bit positions
    localparam int IDX_SIG   = 0;
    localparam int IDX_ALARM = 1;
    localparam int IDX_SEC5  = 2;
    localparam int IDX_SEC1  = 3;
    localparam int IDX_JIT   = 4;
    localparam int IDX_PKT2  = 5;
    localparam int IDX_PKT1  = 6;
    localparam int IDX_PKT0  = 7;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic over;
        logic under;
    } jzone_t;

    typedef struct packed {
        logic   valid;
        logic   [4:0] chan;
        logic   [3:0] code;
    } sig_word_t;

    function automatic jzone_t jit_zone(int unsigned level, int unsigned depth,
                                        int unsigned margin);
        jzone_t z;
        z.under = (level <= margin);
        z.over  = ((level + margin) >= depth);
        return z;
    endfunction

    function automatic src_vec_t pack_sources(logic [2:0] pkt, logic jit,
                                              logic sec1, logic sec5,
                                              logic alarm, logic sig);
        src_vec_t v;
        v            = '0;
        v[IDX_PKT0]  = pkt[0];
        v[IDX_PKT1]  = pkt[1];
        v[IDX_PKT2]  = pkt[2];
        v[IDX_JIT]   = jit;
        v[IDX_SEC1]  = sec1;
        v[IDX_SEC5]  = sec5;
        v[IDX_ALARM] = alarm;
        v[IDX_SIG]   = sig;
        return v;
    endfunction

endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    // R3: an input that was already high in the previous cycle never fires
    a_r3_level_held_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((rise & $past(lvl)) == '0));

endmodule

// File: rtl/irq_sig_watch.sv
module irq_sig_watch #(
    parameter int NUM_CH = 30,
    parameter int CH_W   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic [CH_W-1:0] chan,
    input  logic [3:0]      code,
    output logic            change
);
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] diff;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [3:0] store_q;

        assign hit[c]  = valid && (chan == CH_W'(c));
        assign diff[c] = hit[c] && (store_q != code);

        always_ff @(posedge clk) begin
            if (rst)         store_q <= 4'h0;
            else if (hit[c]) store_q <= code;
        end
    end

    assign change = |diff;

    // R8: an out-of-range channel number never reports a change
    a_r8_range_ignored: assert property (@(posedge clk) disable iff (rst)
        (valid && (int'(chan) >= NUM_CH)) |-> !change);

    // R7: presenting the same code twice in a row for one channel is quiet
    a_r7_repeat_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && valid && $past(valid) && chan == $past(chan)
         && code == $past(code)) |-> !change);

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import fint_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t trig,
    input  logic     clr,
    input  src_vec_t clr_bits,
    input  logic     mask_wr,
    input  src_vec_t mask_wdata,
    output src_vec_t mask,
    output src_vec_t flags,
    output logic     irq
);
    src_vec_t clr_sel;

    assign clr_sel = clr ? clr_bits : '0;

    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)          flags[i] <= 1'b0;
            else if (trig[i]) flags[i] <= 1'b1;
            else if (clr_sel[i]) flags[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          mask <= '0;
        else if (mask_wr) mask <= mask_wdata;
    end

    assign irq = |(flags & mask);

    // R5: a set flag survives every cycle in which it is not selected for clearing
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(flags) & ~$past(clr_sel) & ~flags) == '0));

    // R6: a selected flag with no trigger is gone after the clear
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((flags & $past(clr_bits & ~trig)) == '0));

    // R6: a trigger in the clear cycle wins
    a_r6_trigger_wins: assert property (@(posedge clk) disable iff (rst)
        (trig != '0) |=> ((flags & $past(trig)) == $past(trig)));

endmodule

// File: rtl/frm_irq_agg.sv
module frm_irq_agg
    import fint_pkg::*;
#(
    parameter int NUM_CH = 30,
    parameter int DEPTH  = 32,
    parameter int MARGIN = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       hdlc_evt,
    input  logic [LVL_W-1:0] jit_level,
    input  logic             sec1_stat,
    input  logic             sec5_stat,
    input  logic             alarm_stat,
    input  logic             sig_valid,
    input  logic [CH_W-1:0]  sig_chan,
    input  logic [3:0]       sig_abcd,
    input  logic             mask_wr,
    input  logic [7:0]       mask_wdata,
    output logic [7:0]       mask_rdata,
    input  logic             flag_clr,
    input  logic [7:0]       flag_clr_bits,
    output logic [7:0]       flags,
    output logic             irq
);
    localparam int RISE_W = 5;

    jzone_t            zone;
    logic [RISE_W-1:0] rise_in;
    logic [RISE_W-1:0] rise_out;
    logic              sig_change;
    src_vec_t          trig;

    assign zone    = jit_zone(32'(jit_level), DEPTH, MARGIN);
    assign rise_in = {zone.over, zone.under, alarm_stat, sec5_stat, sec1_stat};

    irq_rise_det #(.W(RISE_W)) u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (rise_in),
        .rise (rise_out)
    );

    irq_sig_watch #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sig (
        .clk    (clk),
        .rst    (rst),
        .valid  (sig_valid),
        .chan   (sig_chan),
        .code   (sig_abcd),
        .change (sig_change)
    );

    assign trig = pack_sources(hdlc_evt, rise_out[3] | rise_out[4],
                               rise_out[0], rise_out[1], rise_out[2],
                               sig_change);

    irq_flag_bank u_flags (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .clr        (flag_clr),
        .clr_bits   (flag_clr_bits),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .mask       (mask_rdata),
        .flags      (flags),
        .irq        (irq)
    );

    // R1: a written mask value is visible on the next cycle
    a_r1_mask_readback: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_rdata == $past(mask_wdata)));

    // R2: with every source blocked the request stays low
    a_r2_all_masked_low: assert property (@(posedge clk) disable iff (rst)
        (mask_rdata == 8'h00) |-> !irq);

    // R4: a fill level strictly between the zones leaves the jitter flag alone
    a_r4_interior_quiet: assert property (@(posedge clk) disable iff (rst)
        ((32'(jit_level) > MARGIN) && (32'(jit_level) + MARGIN < DEPTH) && !flag_clr)
        |=> (flags[IDX_JIT] == $past(flags[IDX_JIT])));

    // R9: a packet controller event always leaves its flag set
    a_r9_pkt0_sets: assert property (@(posedge clk) disable iff (rst)
        hdlc_evt[0] |=> flags[IDX_PKT0]);

endmodule

// File: tb/frm_irq_agg_test.sv
module frm_irq_agg_test;
    localparam int NCH    = 30;
    localparam int DEPTH  = 32;
    localparam int MARGIN = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] hdlc_evt;
    logic [5:0] jit_level;
    logic       sec1_stat, sec5_stat, alarm_stat;
    logic       sig_valid;
    logic [4:0] sig_chan;
    logic [3:0] sig_abcd;
    logic       mask_wr;
    logic [7:0] mask_wdata;
    logic [7:0] mask_rdata;
    logic       flag_clr;
    logic [7:0] flag_clr_bits;
    logic [7:0] flags;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] sig_model [NCH];

    always #4 clk = ~clk;

    frm_irq_agg uut (
        .clk(clk), .rst(rst), .hdlc_evt(hdlc_evt), .jit_level(jit_level),
        .sec1_stat(sec1_stat), .sec5_stat(sec5_stat), .alarm_stat(alarm_stat),
        .sig_valid(sig_valid), .sig_chan(sig_chan), .sig_abcd(sig_abcd),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .flag_clr(flag_clr), .flag_clr_bits(flag_clr_bits), .flags(flags),
        .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_clear(logic [7:0] b);
        flag_clr = 1'b1; flag_clr_bits = b;
        tick();
        flag_clr = 1'b0; flag_clr_bits = 8'h00;
    endtask

    task automatic write_mask(logic [7:0] m);
        mask_wr = 1'b1; mask_wdata = m;
        tick();
        mask_wr = 1'b0;
    endtask

    task automatic present(int ch, logic [3:0] v);
        sig_valid = 1'b1; sig_chan = 5'(ch); sig_abcd = v;
        tick();
        sig_valid = 1'b0;
    endtask

    task automatic raise(int b);
        case (b)
            7: begin hdlc_evt[0] = 1'b1; tick(); hdlc_evt[0] = 1'b0; end
            6: begin hdlc_evt[1] = 1'b1; tick(); hdlc_evt[1] = 1'b0; end
            5: begin hdlc_evt[2] = 1'b1; tick(); hdlc_evt[2] = 1'b0; end
            4: begin jit_level = 6'd2; tick(); jit_level = 6'd16; end
            3: begin sec1_stat = 1'b1; tick(); sec1_stat = 1'b0; end
            2: begin sec5_stat = 1'b1; tick(); sec5_stat = 1'b0; end
            1: begin alarm_stat = 1'b1; tick(); alarm_stat = 1'b0; end
            default: begin
                present(0, sig_model[0] ^ 4'h1);
                sig_model[0] = sig_model[0] ^ 4'h1;
            end
        endcase
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) sig_model[c] = 4'h0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; hdlc_evt = 3'b000; jit_level = 6'd16;
        sec1_stat = 1'b0; sec5_stat = 1'b0; alarm_stat = 1'b0;
        sig_valid = 1'b0; sig_chan = 5'd0; sig_abcd = 4'h0;
        mask_wr = 1'b0; mask_wdata = 8'h00;
        flag_clr = 1'b0; flag_clr_bits = 8'h00;
        tick();
        do_reset();

        // R10: reset state
        chk("R10 flags after reset", 32'(flags), 32'h0);
        chk("R10 mask after reset", 32'(mask_rdata), 32'h0);
        chk("R10 irq after reset", 32'(irq), 32'h0);

        // R1 / R2: each single source against every mask value
        for (int b = 0; b < 8; b++) begin
            do_clear(8'hFF);
            raise(b);
            chk("R2 flag latches while masked", 32'(flags), 32'(1 << b));
            for (int m = 0; m < 256; m++) begin
                write_mask(8'(m));
                chk("R1 mask readback", 32'(mask_rdata), 32'(m));
                chk("R2 irq from flag and mask", 32'(irq), 32'((m >> b) & 1));
            end
        end
        write_mask(8'hFF);
        do_clear(8'hFF);
        chk("R6 clear all", 32'(flags), 32'h0);
        chk("R2 irq low with no flags", 32'(irq), 32'h0);

        // R5: sticky
        raise(4);
        repeat (10) tick();
        chk("R5 flag held", 32'(flags), 32'h10);

        // R6: selective clear
        raise(3); raise(2);
        do_clear(8'h18);
        chk("R6 selective clear", 32'(flags), 32'h04);
        do_clear(8'hFF);

        // R3: rising edge only
        sec5_stat = 1'b1; tick();
        chk("R3 five-second rise", 32'(flags), 32'h04);
        do_clear(8'h04);
        repeat (3) tick();
        chk("R3 five-second level ignored", 32'(flags), 32'h0);
        sec5_stat = 1'b0; tick();
        sec5_stat = 1'b1; tick();
        chk("R3 five-second second rise", 32'(flags), 32'h04);
        sec5_stat = 1'b0;
        do_clear(8'hFF);
        alarm_stat = 1'b1; tick();
        do_clear(8'h02);
        tick();
        chk("R3 alarm level ignored", 32'(flags), 32'h0);
        alarm_stat = 1'b0;
        sec1_stat = 1'b1; tick();
        do_clear(8'h08);
        chk("R3 one-second level ignored", 32'(flags), 32'h0);
        sec1_stat = 1'b0; tick();

        // R9 / R6: event line high during the clear
        hdlc_evt[1] = 1'b1; tick();
        chk("R9 packet 1 sets", 32'(flags), 32'h40);
        do_clear(8'h40);
        chk("R6 trigger beats clear", 32'(flags), 32'h40);
        hdlc_evt[1] = 1'b0;
        do_clear(8'h40);
        chk("R9 packet 1 cleared", 32'(flags), 32'h0);

        // R4: fill-level sweep up and down
        begin
            logic pu, po, u, o, e;
            pu = 1'b0; po = 1'b0;
            for (int k = 0; k < 2 * (DEPTH + 1); k++) begin
                int lvl;
                lvl = (k <= DEPTH) ? k : (2 * DEPTH + 1 - k);
                jit_level = 6'(lvl);
                tick();
                u = (lvl <= MARGIN);
                o = (lvl >= DEPTH - MARGIN);
                e = (u && !pu) || (o && !po);
                chk("R4 jitter zone entry", 32'(flags[4]), 32'(e));
                if (flags[4]) do_clear(8'h10);
                pu = u; po = o;
            end
            jit_level = 6'd16; tick();
            do_clear(8'hFF);
        end

        // R7: every channel, every code, then a repeat
        for (int c = 0; c < NCH; c++) begin
            for (int v = 0; v <= 16; v++) begin
                logic [3:0] val;
                val = (v == 16) ? 4'hF : 4'(v);
                present(c, val);
                chk("R7 signaling change", 32'(flags[0]), 32'(val != sig_model[c]));
                if (flags[0]) do_clear(8'h01);
                sig_model[c] = val;
            end
        end

        // R8: channel numbers above range
        present(30, 4'h3);
        chk("R8 channel 30 ignored", 32'(flags), 32'h0);
        present(31, 4'h9);
        chk("R8 channel 31 ignored", 32'(flags), 32'h0);
        present(29, sig_model[29]);
        chk("R8 no aliasing into channel 29", 32'(flags), 32'h0);

        // R10: reset mid-run clears mask and stored signaling copies
        raise(7);
        do_reset();
        chk("R10 flags after second reset", 32'(flags), 32'h0);
        chk("R10 mask after second reset", 32'(mask_rdata), 32'h0);
        present(5, 4'h0);
        chk("R10 stored code cleared", 32'(flags), 32'h0);
        present(5, 4'hF);
        chk("R7 change after reset", 32'(flags), 32'h01);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule